// File: doc/BRIEF.md
# Serial Overhead Byte Fetcher

This block sits beside a transport-overhead generator. It obtains the value of an overhead byte from an external serial source whenever the generator asks for one. Each request carries a 10-bit byte address, a source flag taken from the top bit of the byte's configuration entry, and the internally generated value for that byte. When the flag is clear, the internal value goes straight back to the insertion logic and the serial port stays quiet.

When the flag is set, the block runs a two-phase serial transfer. First it shifts the address out, high bit first, with an address strobe raised. After one idle bit step it raises a data strobe and shifts in eight data bits, high bit first. The assembled byte and its address are then returned on a result port as a single-cycle pulse.

All serial activity advances only on clocks where a bit-step enable is high. This lets the port run at a fraction of the core clock. A synchronous reset abandons any transfer and returns the port to idle.

Top module: `ohb_fetch`

## Requirements
- R1: During the address phase `ser_addr` carries the 10-bit request address, bit 9 first, one bit per bit step. Outside that phase `ser_addr` is low.
- R2: `ser_ale` is high for exactly 10 bit steps per serial transfer and is low otherwise.
- R3: Exactly one bit step with both `ser_ale` and `ser_dle` low separates the last address step from the first data step.
- R4: `ser_dle` is high for exactly 8 bit steps. On each of them `ser_din` is sampled at the rising edge that ends the step, and the first sample becomes bit 7 of the byte.
- R5: A request with `req_ext` = 0 causes no strobe activity, and `ser_din` has no effect on it. `res_data` equals `req_int_data` and `res_valid` pulses on the cycle after acceptance.
- R6: `req_ready` is high only when no serial transfer is in progress. A request is accepted on a rising edge where both `req_valid` and `req_ready` are high.
- R7: After the 8th data step, `res_valid` is high for one cycle with the request address on `res_addr` and the shifted-in byte on `res_data`. With `bit_en` held high this cycle comes 20 cycles after acceptance.
- R8: On a clock where `bit_en` is low, the serial phase and the driven address bit do not change, and no data bit is sampled.
- R9: A synchronous reset drops both strobes and `ser_addr` on the next cycle, raises `req_ready`, and produces no result for the aborted transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Serial bit-step enable |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | 10 | Overhead byte address |
| req_ext | input | 1 | Source flag: 1 fetches the byte over the serial port |
| req_int_data | input | 8 | Internally generated byte value |
| ser_ale | output | 1 | Address strobe |
| ser_addr | output | 1 | Serial address bit |
| ser_dle | output | 1 | Data strobe |
| ser_din | input | 1 | Serial data bit from the external source |
| res_valid | output | 1 | One-cycle result pulse |
| res_addr | output | 10 | Address of the returned byte |
| res_data | output | 8 | Returned byte value |

## Verification
The bench builds the block with its default widths: a 10-bit address, an 8-bit byte and a single gap step. At these widths, all-ones, all-zeros and alternating addresses and bytes exercise every bit position of both shift registers. One run with `bit_en` gated in a repeating two-on, one-off pattern checks that the phase lengths are counted in bit steps rather than clocks. A reset issued in the middle of a transfer, followed by a clean transfer, shows that the abort leaves no stale result behind.

// File: rtl/ohb_pkg.sv
package ohb_pkg;

    localparam int unsigned OH_ADDR_W = 10;
    localparam int unsigned OH_DATA_W = 8;
    localparam int unsigned OH_GAP    = 1;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_GAP  = 2'd2,
        PH_DATA = 2'd3
    } phase_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ohb_ctrl.sv
module ohb_ctrl
    import ohb_pkg::*;
#(
    parameter int unsigned ADDR_W  = OH_ADDR_W,
    parameter int unsigned DATA_W  = OH_DATA_W,
    parameter int unsigned GAP_CYC = OH_GAP
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   bit_en,
    input  logic   req_valid,
    input  logic   req_ext,
    output logic   req_ready,
    output logic   load_ext,
    output logic   take_int,
    output logic   addr_step,
    output logic   data_step,
    output logic   last_bit,
    output phase_t phase
);

    localparam int unsigned CW = $clog2(max3(ADDR_W, DATA_W, GAP_CYC) + 1);

    logic [CW-1:0] cnt;
    logic          accept;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign load_ext  = accept && req_ext;
    assign take_int  = accept && !req_ext;
    assign addr_step = (phase == PH_ADDR) && bit_en;
    assign data_step = (phase == PH_DATA) && bit_en;
    assign last_bit  = data_step && (cnt == CW'(DATA_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (load_ext) begin
                        phase <= PH_ADDR;
                        cnt   <= '0;
                    end
                end
                PH_ADDR: begin
                    if (bit_en) begin
                        if (cnt == CW'(ADDR_W - 1)) begin
                            phase <= PH_GAP;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_GAP: begin
                    if (bit_en) begin
                        if (cnt == CW'(GAP_CYC - 1)) begin
                            phase <= PH_DATA;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_DATA: begin
                    if (bit_en) begin
                        if (last_bit) begin
                            phase <= PH_IDLE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // The counter never passes the length of the phase it is in.
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ADDR) |-> (cnt <= CW'(ADDR_W - 1))); // R2

    AST_DATA_BOUND: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA) |-> (cnt <= CW'(DATA_W - 1))); // R4

endmodule

// File: rtl/ohb_shift.sv
module ohb_shift
    import ohb_pkg::*;
#(
    parameter int unsigned ADDR_W = OH_ADDR_W,
    parameter int unsigned DATA_W = OH_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_ext,
    input  logic              take_int,
    input  logic              addr_step,
    input  logic              data_step,
    input  logic              last_bit,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_int_data,
    input  logic              ser_din,
    output logic              addr_bit,
    output logic              res_valid,
    output logic [ADDR_W-1:0] res_addr,
    output logic [DATA_W-1:0] res_data
);

    logic [ADDR_W-1:0] a_sr;
    logic [ADDR_W-1:0] a_hold;
    logic [DATA_W-1:0] d_sr;

    assign addr_bit = a_sr[ADDR_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            a_sr   <= '0;
            a_hold <= '0;
        end else if (load_ext) begin
            a_sr   <= req_addr;
            a_hold <= req_addr;
        end else if (addr_step) begin
            a_sr <= {a_sr[ADDR_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d_sr <= '0;
        end else if (data_step) begin
            d_sr <= {d_sr[DATA_W-2:0], ser_din};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_addr  <= '0;
            res_data  <= '0;
        end else begin
            res_valid <= last_bit || take_int;
            if (last_bit) begin
                res_addr <= a_hold;
                res_data <= {d_sr[DATA_W-2:0], ser_din};
            end else if (take_int) begin
                res_addr <= req_addr;
                res_data <= req_int_data;
            end
        end
    end

    // An internal-source result carries the request fields unchanged.
    AST_INT_PASS: assert property (@(posedge clk) disable iff (rst)
        take_int |=> (res_valid && res_data == $past(req_int_data)
                      && res_addr == $past(req_addr))); // R5

endmodule

// File: rtl/ohb_fetch.sv
module ohb_fetch
    import ohb_pkg::*;
#(
    parameter int unsigned ADDR_W  = OH_ADDR_W,
    parameter int unsigned DATA_W  = OH_DATA_W,
    parameter int unsigned GAP_CYC = OH_GAP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_ext,
    input  logic [DATA_W-1:0] req_int_data,
    output logic              ser_ale,
    output logic              ser_addr,
    output logic              ser_dle,
    input  logic              ser_din,
    output logic              res_valid,
    output logic [ADDR_W-1:0] res_addr,
    output logic [DATA_W-1:0] res_data
);

    phase_t phase;
    logic   load_ext;
    logic   take_int;
    logic   addr_step;
    logic   data_step;
    logic   last_bit;
    logic   addr_bit;

    ohb_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .GAP_CYC(GAP_CYC)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (bit_en),
        .req_valid(req_valid),
        .req_ext  (req_ext),
        .req_ready(req_ready),
        .load_ext (load_ext),
        .take_int (take_int),
        .addr_step(addr_step),
        .data_step(data_step),
        .last_bit (last_bit),
        .phase    (phase)
    );

    ohb_shift #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_shift (
        .clk         (clk),
        .rst         (rst),
        .load_ext    (load_ext),
        .take_int    (take_int),
        .addr_step   (addr_step),
        .data_step   (data_step),
        .last_bit    (last_bit),
        .req_addr    (req_addr),
        .req_int_data(req_int_data),
        .ser_din     (ser_din),
        .addr_bit    (addr_bit),
        .res_valid   (res_valid),
        .res_addr    (res_addr),
        .res_data    (res_data)
    );

    assign ser_ale  = (phase == PH_ADDR);
    assign ser_dle  = (phase == PH_DATA);
    assign ser_addr = ser_ale && addr_bit;

    AST_GAP_AFTER_ADDR: assert property (@(posedge clk) disable iff (rst)
        ($fell(ser_ale) && !$past(rst)) |-> !ser_dle); // R3

    AST_RESULT_ON_DLE_END: assert property (@(posedge clk) disable iff (rst)
        ($fell(ser_dle) && !$past(rst)) |-> res_valid); // R7

    AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (rst)
        (ser_ale && !bit_en) |=> (ser_ale && $stable(ser_addr))); // R8

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!ser_ale && !ser_dle && !ser_addr && !res_valid)); // R9

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (ser_ale || ser_dle) |-> !req_ready); // R6

endmodule

// File: tb/sim_ohb_fetch.sv
module sim_ohb_fetch;

    logic       clk = 1'b0;
    logic       rst;
    logic       bit_en;
    logic       req_valid;
    logic       req_ready;
    logic [9:0] req_addr;
    logic       req_ext;
    logic [7:0] req_int_data;
    logic       ser_ale;
    logic       ser_addr;
    logic       ser_dle;
    logic       ser_din;
    logic       res_valid;
    logic [9:0] res_addr;
    logic [7:0] res_data;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    ohb_fetch u0 (
        .clk         (clk),
        .rst         (rst),
        .bit_en      (bit_en),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .req_ext     (req_ext),
        .req_int_data(req_int_data),
        .ser_ale     (ser_ale),
        .ser_addr    (ser_addr),
        .ser_dle     (ser_dle),
        .ser_din     (ser_din),
        .res_valid   (res_valid),
        .res_addr    (res_addr),
        .res_data    (res_data)
    );

    // {ext, addr[9:0], internal byte, serial byte}
    localparam logic [26:0] VEC [6] = '{
        {1'b1, 10'h3FF, 8'h00, 8'hA5},
        {1'b1, 10'h001, 8'hFF, 8'h3C},
        {1'b0, 10'h155, 8'h5A, 8'h00},
        {1'b1, 10'h2AA, 8'h11, 8'h80},
        {1'b0, 10'h200, 8'hC3, 8'hFF},
        {1'b1, 10'h000, 8'h77, 8'h01}
    };

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One request from acceptance to result; gated selects a stepped bit_en pattern.
    task automatic xfer(input logic ext, input logic [9:0] addr, input logic [7:0] idata,
                        input logic [7:0] sbyte, input logic gated);
        int       ale_n = 0;
        int       gap_n = 0;
        int       dle_n = 0;
        int       lat   = 0;
        int       busy_ready = 0;
        int       strobes = 0;
        logic [9:0] cap = '0;
        @(negedge clk);
        req_valid    = 1'b1;
        req_ext      = ext;
        req_addr     = addr;
        req_int_data = idata;
        ser_din      = 1'b1;
        chk(req_ready === 1'b1, "R6 ready when idle", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        for (int n = 1; n < 200; n++) begin
            cyc++;
            bit_en = gated ? (cyc % 3 != 2) : 1'b1;
            if (res_valid) begin
                lat = n;
                break;
            end
            if (ser_ale || ser_dle) strobes++;
            if (req_ready && (ser_ale || ser_dle)) busy_ready++;
            if (ser_ale && bit_en) begin
                cap = {cap[8:0], ser_addr};
                ale_n++;
            end
            if (!ser_ale && !ser_dle && ale_n == 10 && dle_n == 0 && bit_en) gap_n++;
            if (ser_dle) begin
                ser_din = (dle_n < 8) ? sbyte[7 - dle_n] : 1'b0;
                if (bit_en) dle_n++;
            end else if (!ext) begin
                ser_din = ~ser_din;
            end
            @(negedge clk);
        end
        bit_en = 1'b1;
        chk(lat != 0, "R7 result appeared", lat, 1);
        chk(res_addr === addr, "R7 result address", res_addr, addr);
        if (ext) begin
            chk(res_data === sbyte, "R4 serial byte assembled MSB first", res_data, sbyte);
            chk(cap === addr, "R1 address shifted out MSB first", cap, addr);
            chk(ale_n == 10, "R2 address strobe length", ale_n, 10);
            chk(gap_n == 1, "R3 single gap step", gap_n, 1);
            chk(dle_n == 8, "R4 data strobe length", dle_n, 8);
            chk(busy_ready == 0, "R6 not ready while busy", busy_ready, 0);
            if (!gated) chk(lat == 20, "R7 latency with steady bit_en", lat, 20);
        end else begin
            chk(res_data === idata, "R5 internal byte returned", res_data, idata);
            chk(strobes == 0, "R5 no strobes for internal byte", strobes, 0);
            chk(lat == 1, "R5 result one cycle after accept", lat, 1);
        end
        @(negedge clk);
        chk(res_valid === 1'b0, "R7 result pulse lasts one cycle", res_valid, 0);
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seen;
        rst = 1'b1; bit_en = 1'b1; req_valid = 1'b0; req_addr = '0;
        req_ext = 1'b0; req_int_data = '0; ser_din = 1'b0;
        repeat (3) @(negedge clk);
        chk(!ser_ale && !ser_dle && !ser_addr && !res_valid, "R9 reset state quiet",
            {ser_ale, ser_dle, ser_addr, res_valid}, 0);
        chk(req_ready === 1'b1, "R9 ready in reset", req_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(ser_addr === 1'b0, "R1 address line low while idle", ser_addr, 0);

        for (int i = 0; i < 6; i++)
            xfer(VEC[i][26], VEC[i][25:16], VEC[i][15:8], VEC[i][7:0], 1'b0);

        // R8: stepped bit_en stretches the phases without changing their step counts.
        xfer(1'b1, 10'h2D3, 8'h00, 8'h96, 1'b1);
        xfer(1'b0, 10'h0F0, 8'h4B, 8'h00, 1'b1);

        // R9: reset in the middle of the address phase aborts the transfer.
        @(negedge clk);
        req_valid = 1'b1; req_ext = 1'b1; req_addr = 10'h1C7; req_int_data = 8'h00;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        chk(ser_ale === 1'b1, "R2 strobe high before abort", ser_ale, 1);
        rst = 1'b1;
        @(negedge clk);
        chk(!ser_ale && !ser_dle && !ser_addr, "R9 strobes dropped by reset",
            {ser_ale, ser_dle, ser_addr}, 0);
        chk(req_ready === 1'b1, "R9 ready after abort", req_ready, 1);
        rst = 1'b0;
        seen = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (res_valid || ser_ale || ser_dle) seen++;
        end
        chk(seen == 0, "R9 no result from aborted transfer", seen, 0);
        xfer(1'b1, 10'h1C7, 8'h00, 8'h5E, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule